// File: doc/BRIEF.md
# Texture Coordinate Clamp, Wrap and Mirror Stage

This stage handles one texture coordinate axis. Two copies, one for s and one for t, sit side by side in a texture pipeline. Each copy takes a perspective-corrected signed fixed-point coordinate together with the tile settings of the current primitive: tile origin and tile end, shift amount, mask width, clamp enable and mirror enable, plus flags for load and copy modes. The stage applies the shift and subtracts the tile origin. It then clamps the result against the tile bounds, and wraps or mirrors the integer part into a power-of-two window. It returns an integer texel coordinate, a 5-bit subtexel fraction and a few status flags.

Coordinates arrive on a valid/ready stream. A transfer happens on a rising clock edge when `in_valid` and `in_ready` are both high. The tile settings and mode flags are sampled together with `in_coord` in that same transfer, so new settings take effect on the next accepted coordinate. Results appear on the output stream one clock after the transfer. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every output holds its value and no new coordinate is taken. `in_valid` must not depend on `in_ready`.

Top module: `tex_coord_wrap`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. An accepted coordinate shows up on the outputs with `out_valid` high one clock later. While `out_valid && !out_ready`, all outputs stay unchanged. `out_valid` is low after reset.
- R2: All coordinates use a signed 16-bit two's-complement format with 5 fraction bits. The input coordinate is arithmetically right-shifted by `shift_amt` (0 to 15) unless `load_mode` is high, in which case it passes through unshifted.
- R3: The tile-relative value is the shifted coordinate minus `tile_lo`, computed at 17 bits. Without a clamp, `out_frac` is its low 5 bits. The integer part is that value shifted right arithmetically by 5, taken as 12-bit two's complement.
- R4: Clamping is active when `(clamp_en || mask_bits == 0) && !load_mode && !copy_mode`. When clamping is active and the tile-relative value is negative, the integer part becomes 0 and `out_frac` becomes 0.
- R5: When clamping is active and the tile-relative value is strictly greater than `tile_hi - tile_lo`, the integer part becomes `(tile_hi - tile_lo) >> 5` and `out_frac` becomes 0. A value equal to the bound is not clamped. `tile_hi >= tile_lo` is assumed.
- R6: `load_mode` or `copy_mode` disables both clamps, and so does a nonzero `mask_bits` with `clamp_en` low. In these cases negative or over-range values pass through unclamped.
- R7: `mask_bits` from 1 to 9 keeps that many low bits of the integer part and zeroes the rest. Values 10 to 15 act as 9. With 0, the integer part passes unmasked.
- R8: With nonzero `mask_bits`, `out_wrap` is bit number m of the clamped integer part, where m is the effective mask width; with zero mask it is 0. When `mirror_en` and the wrap bit are both set, the kept low bits are inverted.
- R9: `out_mask_en` is high exactly when `mask_bits != 0`. `out_low_ones` is high when `out_texel[3:0] == 4'hF`. `out_low_zeros` is high when `out_texel[3:0] == 4'h0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input coordinate valid |
| in_ready | output | 1 | Stage can accept a coordinate |
| in_coord | input | 16 | Signed coordinate, 5 fraction bits |
| tile_lo | input | 16 | Tile origin, same format |
| tile_hi | input | 16 | Tile end, same format |
| shift_amt | input | 4 | Right-shift amount |
| mask_bits | input | 4 | Wrap window width in bits, 0 = off |
| clamp_en | input | 1 | Clamp enable |
| mirror_en | input | 1 | Mirror enable |
| load_mode | input | 1 | Load mode: no shift, no clamp |
| copy_mode | input | 1 | Copy mode: no clamp |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts result |
| out_texel | output | 12 | Integer texel coordinate |
| out_frac | output | 5 | Subtexel fraction |
| out_mask_en | output | 1 | Masking was enabled |
| out_wrap | output | 1 | Wrap bit |
| out_low_ones | output | 1 | Low 4 texel bits all one |
| out_low_zeros | output | 1 | Low 4 texel bits all zero |

## Verification
The bench drives negative coordinates with large shifts. A logical shift in place of an arithmetic one would turn these into huge positive texels. It places the tile-relative value exactly on the upper bound, where a greater-or-equal compare would wrongly drop the fraction. It sweeps the mask through every value from 1 to 15: an off-by-one window, or a missing saturation at 9, leaves stray high bits. It also mirrors values on both sides of the wrap bit, and stalls the output to catch results that get overwritten under back-pressure.

// File: rtl/tcw_pkg.sv
package tcw_pkg;
  parameter int TCW_COORD_W = 16;
  parameter int TCW_FRAC_W  = 5;
  parameter int TCW_SHIFT_W = 4;
  parameter int TCW_MASK_W  = 4;
  parameter int TCW_MASK_MAX = 9;
  parameter int TCW_FLAG_W  = 4;
endpackage

// File: rtl/tcw_offset.sv
module tcw_offset #(
  parameter int COORD_W = tcw_pkg::TCW_COORD_W,
  parameter int SHIFT_W = tcw_pkg::TCW_SHIFT_W,
  localparam int TILE_W = COORD_W + 1
) (
  input  logic [COORD_W-1:0] coord,
  input  logic [COORD_W-1:0] lo,
  input  logic [COORD_W-1:0] hi,
  input  logic [SHIFT_W-1:0] shamt,
  input  logic               load,
  output logic [TILE_W-1:0]  tile,
  output logic [TILE_W-1:0]  span
);
  logic signed [COORD_W-1:0] c_s;
  logic signed [COORD_W-1:0] shifted;

  always_comb begin
    c_s     = coord;
    shifted = load ? c_s : (c_s >>> shamt);
    tile    = {shifted[COORD_W-1], shifted} - {lo[COORD_W-1], lo};
    span    = {hi[COORD_W-1], hi} - {lo[COORD_W-1], lo};
  end
endmodule

// File: rtl/tcw_clamp.sv
module tcw_clamp #(
  parameter int TILE_W = tcw_pkg::TCW_COORD_W + 1,
  parameter int FRAC_W = tcw_pkg::TCW_FRAC_W,
  localparam int INT_W = TILE_W - FRAC_W
) (
  input  logic [TILE_W-1:0] tile,
  input  logic [TILE_W-1:0] span,
  input  logic              clamp_en,
  input  logic              mask_zero,
  input  logic              load,
  input  logic              copy,
  output logic              under,
  output logic              over,
  output logic [INT_W-1:0]  int_part,
  output logic [FRAC_W-1:0] frac
);
  logic active;

  always_comb begin
    active = (clamp_en || mask_zero) && !load && !copy;
    under  = active && tile[TILE_W-1];
    over   = active && !tile[TILE_W-1] && ($signed(tile) > $signed(span));
    if (under) begin
      int_part = '0;
      frac     = '0;
    end else if (over) begin
      int_part = span[TILE_W-1:FRAC_W];
      frac     = '0;
    end else begin
      int_part = tile[TILE_W-1:FRAC_W];
      frac     = tile[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/tcw_wrap.sv
module tcw_wrap #(
  parameter int INT_W    = tcw_pkg::TCW_COORD_W + 1 - tcw_pkg::TCW_FRAC_W,
  parameter int MASK_W   = tcw_pkg::TCW_MASK_W,
  parameter int MASK_MAX = tcw_pkg::TCW_MASK_MAX
) (
  input  logic [INT_W-1:0]  int_in,
  input  logic [MASK_W-1:0] mask,
  input  logic              mirror,
  output logic [INT_W-1:0]  texel,
  output logic              wrap
);
  logic [MASK_W-1:0] msat;
  logic [INT_W-1:0]  keep;

  assign msat = (int'(mask) > MASK_MAX) ? MASK_W'(MASK_MAX) : mask;

  for (genvar i = 0; i < INT_W; i++) begin : g_keep
    assign keep[i] = (i < int'(msat));
  end

  always_comb begin
    if (mask == '0) begin
      wrap  = 1'b0;
      texel = int_in;
    end else begin
      wrap  = int_in[msat];
      texel = (int_in & keep) ^ (keep & {INT_W{mirror && wrap}});
    end
  end
endmodule

// File: rtl/tex_coord_wrap.sv
module tex_coord_wrap #(
  parameter int COORD_W  = tcw_pkg::TCW_COORD_W,
  parameter int FRAC_W   = tcw_pkg::TCW_FRAC_W,
  parameter int SHIFT_W  = tcw_pkg::TCW_SHIFT_W,
  parameter int MASK_W   = tcw_pkg::TCW_MASK_W,
  parameter int MASK_MAX = tcw_pkg::TCW_MASK_MAX,
  parameter int FLAG_W   = tcw_pkg::TCW_FLAG_W,
  localparam int TILE_W  = COORD_W + 1,
  localparam int TEX_W   = TILE_W - FRAC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [COORD_W-1:0] in_coord,
  input  logic [COORD_W-1:0] tile_lo,
  input  logic [COORD_W-1:0] tile_hi,
  input  logic [SHIFT_W-1:0] shift_amt,
  input  logic [MASK_W-1:0]  mask_bits,
  input  logic               clamp_en,
  input  logic               mirror_en,
  input  logic               load_mode,
  input  logic               copy_mode,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [TEX_W-1:0]   out_texel,
  output logic [FRAC_W-1:0]  out_frac,
  output logic               out_mask_en,
  output logic               out_wrap,
  output logic               out_low_ones,
  output logic               out_low_zeros
);
  logic [TILE_W-1:0] tile_v, span_v;
  logic              under_c, over_c;
  logic [TEX_W-1:0]  int_c, texel_c;
  logic [FRAC_W-1:0] frac_c;
  logic              wrap_c;
  logic              take;

  tcw_offset #(.COORD_W(COORD_W), .SHIFT_W(SHIFT_W)) u_offset (
    .coord(in_coord), .lo(tile_lo), .hi(tile_hi), .shamt(shift_amt),
    .load(load_mode), .tile(tile_v), .span(span_v)
  );

  tcw_clamp #(.TILE_W(TILE_W), .FRAC_W(FRAC_W)) u_clamp (
    .tile(tile_v), .span(span_v), .clamp_en(clamp_en),
    .mask_zero(mask_bits == '0), .load(load_mode), .copy(copy_mode),
    .under(under_c), .over(over_c), .int_part(int_c), .frac(frac_c)
  );

  tcw_wrap #(.INT_W(TEX_W), .MASK_W(MASK_W), .MASK_MAX(MASK_MAX)) u_wrap (
    .int_in(int_c), .mask(mask_bits), .mirror(mirror_en),
    .texel(texel_c), .wrap(wrap_c)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_texel     <= '0;
      out_frac      <= '0;
      out_mask_en   <= 1'b0;
      out_wrap      <= 1'b0;
      out_low_ones  <= 1'b0;
      out_low_zeros <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take) begin
        out_texel     <= texel_c;
        out_frac      <= frac_c;
        out_mask_en   <= (mask_bits != '0);
        out_wrap      <= wrap_c;
        out_low_ones  <= &texel_c[FLAG_W-1:0];
        out_low_zeros <= ~|texel_c[FLAG_W-1:0];
      end
    end
  end

  // R1
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_texel) && $stable(out_frac)
      && $stable(out_wrap) && $stable(out_mask_en)));
  // R1
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  // R1
  idle_drains_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && in_ready) |=> !out_valid);
  // R4
  under_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && under_c) |=> (out_texel == '0 && out_frac == '0));
  // R5
  over_frac_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && over_c) |=> (out_frac == '0));
  // R8
  wrap_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_mask_en) |-> !out_wrap);
  // R9
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_low_ones && out_low_zeros));
endmodule

// File: tb/tb_tex_coord_wrap.sv
`timescale 1ns/1ps
module tb_tex_coord_wrap;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [15:0] in_coord = '0, tile_lo = '0, tile_hi = '0;
  logic [3:0]  shift_amt = '0, mask_bits = '0;
  logic        clamp_en = 0, mirror_en = 0, load_mode = 0, copy_mode = 0;
  logic        out_valid, out_ready = 1'b1;
  logic [11:0] out_texel;
  logic [4:0]  out_frac;
  logic        out_mask_en, out_wrap, out_low_ones, out_low_zeros;

  int vecs = 0, errs = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tex_coord_wrap dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_coord(in_coord), .tile_lo(tile_lo), .tile_hi(tile_hi),
    .shift_amt(shift_amt), .mask_bits(mask_bits), .clamp_en(clamp_en),
    .mirror_en(mirror_en), .load_mode(load_mode), .copy_mode(copy_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_texel(out_texel),
    .out_frac(out_frac), .out_mask_en(out_mask_en), .out_wrap(out_wrap),
    .out_low_ones(out_low_ones), .out_low_zeros(out_low_zeros)
  );

  task automatic check(string req, string what, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected result from the requirements, using plain integer arithmetic
  task automatic model(input int c, lo, hi, sh, msk, input bit clp, mir, ld, cp,
                       output int tex, fr, wr);
    int t, span, ip, m, win;
    bit act;
    t    = (ld ? c : (c >>> sh)) - lo;
    span = hi - lo;
    act  = (clp || msk == 0) && !ld && !cp;
    if (act && t < 0) begin ip = 0; fr = 0; end
    else if (act && t > span) begin ip = span / 32; fr = 0; end
    else begin ip = t >>> 5; fr = t & 31; end
    m = (msk > 9) ? 9 : msk;
    if (m == 0) begin tex = ip & 12'hFFF; wr = 0; end
    else begin
      win = (1 << m) - 1;
      wr  = (ip >> m) & 1;
      tex = ip & win;
      if (mir && wr == 1) tex = win - tex;
    end
  endtask

  task automatic drive(int c, lo, hi, sh, msk, bit clp, mir, ld, cp);
    in_coord = 16'(c); tile_lo = 16'(lo); tile_hi = 16'(hi);
    shift_amt = 4'(sh); mask_bits = 4'(msk);
    clamp_en = clp; mirror_en = mir; load_mode = ld; copy_mode = cp;
    in_valid = 1'b1;
  endtask

  task automatic compare(string req, int c, lo, hi, sh, msk, bit clp, mir, ld, cp);
    int tex, fr, wr;
    model(c, lo, hi, sh, msk, clp, mir, ld, cp, tex, fr, wr);
    check(req, "out_valid", int'(out_valid), 1);
    check(req, "texel", int'(out_texel), tex);
    check(req, "frac", int'(out_frac), fr);
    check(req, "wrap", int'(out_wrap), wr);
    check("R9", "mask_en", int'(out_mask_en), int'(msk != 0));
    check("R9", "low_ones", int'(out_low_ones), int'((tex & 15) == 15));
    check("R9", "low_zeros", int'(out_low_zeros), int'((tex & 15) == 0));
  endtask

  task automatic apply(string req, int c, lo, hi, sh, msk, bit clp, mir, ld, cp);
    @(negedge clk);
    out_ready = 1'b1;
    drive(c, lo, hi, sh, msk, clp, mir, ld, cp);
    @(negedge clk);
    in_valid = 1'b0;
    compare(req, c, lo, hi, sh, msk, clp, mir, ld, cp);
  endtask

  task automatic t_reset;
    check("R1", "out_valid after reset", int'(out_valid), 0);
    check("R1", "in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_shift; // R2
    apply("R2", -100, 0, 0, 2, 0, 0, 0, 0, 1);
    apply("R2", -32768, 0, 0, 15, 0, 0, 0, 0, 1);
    apply("R2", 5000, 0, 0, 3, 0, 0, 0, 0, 1);
    apply("R2", 5000, 0, 8000, 3, 0, 0, 0, 1, 0);
  endtask

  task automatic t_subtract; // R3
    apply("R3", 1000, 200, 2000, 0, 0, 1, 0, 0, 0);
    apply("R3", 32767, -32768, 0, 0, 0, 0, 0, 0, 1);
    apply("R3", 777, 13, 5000, 0, 0, 1, 0, 0, 0);
  endtask

  task automatic t_under; // R4
    apply("R4", 10, 100, 2000, 0, 0, 1, 0, 0, 0);
    apply("R4", -32768, 32767, 32767, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_over; // R5
    apply("R5", 3000, 100, 1000, 0, 0, 1, 0, 0, 0);
    apply("R5", 1000, 100, 1000, 0, 0, 1, 0, 0, 0);
    apply("R5", 1001, 100, 1000, 0, 0, 1, 0, 0, 0);
  endtask

  task automatic t_gate; // R6
    apply("R6", 10, 100, 2000, 0, 0, 1, 0, 1, 0);
    apply("R6", 3000, 100, 1000, 0, 0, 1, 0, 0, 1);
    apply("R6", 10, 100, 2000, 0, 5, 0, 0, 0, 0);
    apply("R6", 9000, 0, 1000, 0, 9, 0, 0, 0, 0);
  endtask

  task automatic t_mask; // R7
    for (int m = 0; m < 16; m++)
      apply("R7", 32736, 0, 0, 0, m, 0, 0, 0, 1);
    apply("R7", 1234 * 16, 0, 0, 0, 6, 0, 0, 0, 1);
  endtask

  task automatic t_mirror; // R8
    apply("R8", 32'h13 * 32, 0, 0, 0, 4, 0, 1, 0, 1);
    apply("R8", 32'h03 * 32, 0, 0, 0, 4, 0, 1, 0, 1);
    apply("R8", 32'h20 * 32, 0, 0, 0, 4, 0, 1, 0, 1);
    apply("R8", 32'h13 * 32, 0, 0, 0, 4, 0, 0, 0, 1);
    apply("R8", 32'h3F0 * 32, 0, 0, 0, 12, 0, 1, 0, 1);
  endtask

  task automatic t_flags; // R9
    apply("R9", 32'h1F * 32, 0, 0, 0, 0, 0, 0, 0, 1);
    apply("R9", 32'h10 * 32, 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_stall; // R1
    @(negedge clk);
    out_ready = 1'b0;
    drive(640, 0, 0, 0, 0, 0, 0, 0, 1);
    @(negedge clk);
    compare("R1", 640, 0, 0, 0, 0, 0, 0, 0, 1);
    drive(320, 0, 0, 0, 0, 0, 0, 0, 1);
    check("R1", "in_ready during stall", int'(in_ready), 0);
    @(negedge clk);
    compare("R1", 640, 0, 0, 0, 0, 0, 0, 0, 1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    compare("R1", 320, 0, 0, 0, 0, 0, 0, 0, 1);
    @(negedge clk);
    check("R1", "out_valid drained", int'(out_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_shift();
    t_subtract();
    t_under();
    t_over();
    t_gate();
    t_mask();
    t_mirror();
    t_flags();
    t_stall();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule